// File: doc/BRIEF.md
# Supply Window Qualifier

This block is the digital half of a single-input supply window monitor. Two comparator levels arrive from the analog side: one high when the monitored supply is above the undervoltage threshold, one high when it is above the overvoltage threshold. A third input says whether the block's own supply is above its lockout level. A tick from a shared timebase is the unit for every delay. From these inputs the block produces a registered enable for an external pass-transistor gate driver, and a status code that classifies the supply.

The first assertion of the enable requires the supply to stay inside the window, without a break, for a power-on qualification delay. Once enabled, an excursion out of the window is filtered: only an excursion that lasts for the filter time removes the enable. The filter applies only to the edge that leaves the window. A return into the window after a qualified fault restores the enable at once, with no latching and no new power-on delay. Pulling the monitored input low from outside therefore works as a disable input, through the normal undervoltage path. Both delays are parameters counted in ticks. The default of 1550 ticks at a 1 MHz tick gives 1.55 ms for each.

Top module: `supply_window_qualifier`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `gateEn` is 0 and `winStatus` reports undervoltage (2'b01).
- R2: While enabled, an out-of-window condition that lasts for `FLT_TICKS` ticks drives `gateEn` to 0 at the clock edge that samples the last of those ticks. The filter advances only on ticks.
- R3: An out-of-window excursion that ends before `FLT_TICKS` ticks leaves `gateEn` at 1. Each new excursion starts its filter count from zero.
- R4: `gateEn` rises only after the input has been inside the window for `POR_TICKS` ticks since qualification began. It rises at the edge that samples the last of those ticks.
- R5: If the input leaves the window during the power-on delay, the delay restarts from zero on the next entry into the window.
- R6: When `supplyOk` is 0, `gateEn` is 0 after the next clock edge, whatever the window inputs are. After `supplyOk` returns, a full power-on delay is required again.
- R7: After a qualified fault, re-entry into the window restores `gateEn` with no filtering and no power-on delay. The window inputs pass through `SYNC_STAGES` flip-flops, so the output changes `SYNC_STAGES`+1 edges after the input changes.
- R8: A rising `aboveOv` (with `aboveUv` high) is an overvoltage excursion and goes through the same filter as undervoltage.
- R9: `winStatus` uses 2'b00 for in window, 2'b01 for undervoltage and 2'b10 for overvoltage, and never shows 2'b11. When `aboveUv` is 0, undervoltage is reported whatever `aboveOv` is.
- R10: While `gateEn` is 1, `winStatus` is 2'b00, including while an excursion is still being filtered. While `gateEn` is 0, `winStatus` classifies the synchronised inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supplyOk | input | 1 | High when the block's own supply is above the lockout level |
| aboveUv | input | 1 | Comparator level: supply above the undervoltage threshold |
| aboveOv | input | 1 | Comparator level: supply above the overvoltage threshold |
| tick | input | 1 | One-cycle pulse from the shared timebase |
| gateEn | output | 1 | Registered enable for the gate driver |
| winStatus | output | 2 | Window classification (00 ok, 01 under, 10 over) |

## Verification
The hardest cases to reach from the ports are the ones where the enable must not move: an excursion that ends one tick short of the filter time, and a power-on delay interrupted part way through. The stimulus drives the timebase tick directly, one pulse at a time, so it can stop exactly one tick before each threshold and then add the final tick. Between these steps it holds the window inputs for a known number of cycles to cover the synchroniser latency. Interrupted runs are then lengthened so that they would already have fired if the count had not restarted.

// File: rtl/swq_types_pkg.sv
package swq_types_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_QUAL  = 2'd1,
    ST_ON    = 2'd2,
    ST_FAULT = 2'd3
  } qualState_t;

  typedef enum logic [1:0] {
    WIN_OK    = 2'b00,
    WIN_UNDER = 2'b01,
    WIN_OVER  = 2'b10
  } winCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // clear the shared delay counter
    logic cntRun;   // count ticks this cycle
    logic selFlt;   // compare against filter limit (else power-on limit)
    logic enNext;   // value the enable register takes at this edge
  } swqStrobes_t;

endpackage

// File: rtl/swq_datapath.sv
module swq_datapath
  import swq_types_pkg::*;
#(
  parameter int POR_TICKS   = 1550,
  parameter int FLT_TICKS   = 1550,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        aboveUvIn,
  input  logic        aboveOvIn,
  input  swqStrobes_t strobes,
  output logic        inWin,
  output logic        porDone,
  output logic        fltDone,
  output logic        gateEn,
  output logic [1:0]  winStatus
);

  localparam int MAX_TICKS = (POR_TICKS > FLT_TICKS) ? POR_TICKS : FLT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_TICKS - 1);
  localparam logic [CNT_W-1:0] FLT_LAST = CNT_W'(FLT_TICKS - 1);

  logic uvSync;
  logic ovSync;

  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign uvSync = aboveUvIn;
      assign ovSync = aboveOvIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] uvPipe;
      logic [SYNC_STAGES-1:0] ovPipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          uvPipe <= '0;
          ovPipe <= '0;
        end else begin
          uvPipe[0] <= aboveUvIn;
          ovPipe[0] <= aboveOvIn;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            uvPipe[i] <= uvPipe[i-1];
            ovPipe[i] <= ovPipe[i-1];
          end
        end
      end
      assign uvSync = uvPipe[SYNC_STAGES-1];
      assign ovSync = ovPipe[SYNC_STAGES-1];
    end
  endgenerate

  // classification, undervoltage has priority
  winCode_t winClass;
  always_comb begin
    if (!uvSync)     winClass = WIN_UNDER;
    else if (ovSync) winClass = WIN_OVER;
    else             winClass = WIN_OK;
  end
  assign inWin = (winClass == WIN_OK);

  // shared tick counter for both delays
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] cntLast;
  logic             lastTick;

  assign cntLast  = strobes.selFlt ? FLT_LAST : POR_LAST;
  assign lastTick = strobes.cntRun && tick && (tickCnt == cntLast);
  assign porDone  = lastTick && !strobes.selFlt;
  assign fltDone  = lastTick && strobes.selFlt;

  always_ff @(posedge clk) begin
    if (rst || strobes.cntClr) begin
      tickCnt <= '0;
    end else if (strobes.cntRun && tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gateEn    <= 1'b0;
      winStatus <= WIN_UNDER;
    end else begin
      gateEn    <= strobes.enNext;
      winStatus <= strobes.enNext ? WIN_OK : winClass;
    end
  end

endmodule

// File: rtl/swq_control.sv
module swq_control
  import swq_types_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        supplyOk,
  input  logic        inWin,
  input  logic        porDone,
  input  logic        fltDone,
  output swqStrobes_t strobes
);

  qualState_t state;
  qualState_t stateNext;

  always_comb begin
    stateNext      = state;
    strobes        = '0;
    strobes.cntClr = 1'b1;
    if (!supplyOk) begin
      stateNext = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (inWin) stateNext = ST_QUAL;
        end
        ST_QUAL: begin
          if (!inWin) begin
            stateNext = ST_WAIT;
          end else begin
            strobes.cntClr = 1'b0;
            strobes.cntRun = 1'b1;
            if (porDone) begin
              stateNext      = ST_ON;
              strobes.cntClr = 1'b1;
            end
          end
        end
        ST_ON: begin
          if (!inWin) begin
            strobes.cntClr = 1'b0;
            strobes.cntRun = 1'b1;
            strobes.selFlt = 1'b1;
            if (fltDone) begin
              stateNext      = ST_FAULT;
              strobes.cntClr = 1'b1;
            end
          end
        end
        ST_FAULT: begin
          if (inWin) stateNext = ST_ON;
        end
        default: stateNext = ST_WAIT;
      endcase
    end
    strobes.enNext = (stateNext == ST_ON);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= stateNext;
  end

endmodule

// File: rtl/supply_window_qualifier.sv
module supply_window_qualifier
  import swq_types_pkg::*;
#(
  parameter int POR_TICKS   = 1550,
  parameter int FLT_TICKS   = 1550,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supplyOk,
  input  logic       aboveUv,
  input  logic       aboveOv,
  input  logic       tick,
  output logic       gateEn,
  output logic [1:0] winStatus
);

  swqStrobes_t strobes;
  logic        inWin;
  logic        porDone;
  logic        fltDone;

  swq_control i_control (
    .clk      (clk),
    .rst      (rst),
    .supplyOk (supplyOk),
    .inWin    (inWin),
    .porDone  (porDone),
    .fltDone  (fltDone),
    .strobes  (strobes)
  );

  swq_datapath #(
    .POR_TICKS   (POR_TICKS),
    .FLT_TICKS   (FLT_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .aboveUvIn (aboveUv),
    .aboveOvIn (aboveOv),
    .strobes   (strobes),
    .inWin     (inWin),
    .porDone   (porDone),
    .fltDone   (fltDone),
    .gateEn    (gateEn),
    .winStatus (winStatus)
  );

endmodule

// File: rtl/swq_checker.sv
module swq_checker (
  input logic       clk,
  input logic       rst,
  input logic       supplyOk,
  input logic       tick,
  input logic       gateEn,
  input logic [1:0] winStatus
);

  // R6: lockout removes the enable on the next edge
  p_lockout_r6: assert property (@(posedge clk) disable iff (rst)
    !supplyOk |=> !gateEn);

  // R9: the unused status code never appears
  p_status_code_r9: assert property (@(posedge clk) disable iff (rst)
    winStatus != 2'b11);

  // R10: enabled implies an in-window status
  p_on_ok_r10: assert property (@(posedge clk) disable iff (rst)
    gateEn |-> winStatus == 2'b00);

  // R2: apart from lockout, the enable only falls on a sampled tick
  p_drop_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(gateEn) && $past(supplyOk)) |-> $past(tick));

endmodule

bind supply_window_qualifier swq_checker i_checker (
  .clk       (clk),
  .rst       (rst),
  .supplyOk  (supplyOk),
  .tick      (tick),
  .gateEn    (gateEn),
  .winStatus (winStatus)
);

// File: tb/test_supply_window_qualifier.sv
module test_supply_window_qualifier;

  localparam int POR = 6;
  localparam int FLT = 4;
  localparam int SYN = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       supplyOk;
  logic       aboveUv;
  logic       aboveOv;
  logic       tick;
  logic       gateEn;
  logic [1:0] winStatus;

  always #2.5 clk = ~clk;

  supply_window_qualifier #(
    .POR_TICKS   (POR),
    .FLT_TICKS   (FLT),
    .SYNC_STAGES (SYN)
  ) i_supply_window_qualifier (
    .clk       (clk),
    .rst       (rst),
    .supplyOk  (supplyOk),
    .aboveUv   (aboveUv),
    .aboveOv   (aboveOv),
    .tick      (tick),
    .gateEn    (gateEn),
    .winStatus (winStatus)
  );

  typedef struct {
    logic       en;
    logic [1:0] st;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int nCompared = 0;
  int nMismatch = 0;
  bit finished  = 1'b0;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      wait (expQ.size() != 0);
      begin
        expItem_t it;
        it = expQ.pop_front();
        nCompared++;
        if (gateEn !== it.en || winStatus !== it.st) begin
          nMismatch++;
          $display("FAIL %s: gateEn=%0b winStatus=%02b expected gateEn=%0b winStatus=%02b",
                   it.tag, gateEn, winStatus, it.en, it.st);
        end
      end
    end
  end

  task automatic expectOut(input logic en, input logic [1:0] st, input string tag);
    expItem_t it;
    it.en = en; it.st = st; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    rst = 1'b1; supplyOk = 1'b1; aboveUv = 1'b0; aboveOv = 1'b0; tick = 1'b0;
    cycles(3);
    expectOut(1'b0, 2'b01, "R1 reset state");
    rst = 1'b0;
    cycles(1);
    expectOut(1'b0, 2'b01, "R1 first cycle after reset");

    // R5: interrupted power-on delay
    aboveUv = 1'b1;
    cycles(4);
    ticks(3);
    aboveUv = 1'b0;
    cycles(4);
    expectOut(1'b0, 2'b01, "R5 left window during delay");
    aboveUv = 1'b1;
    cycles(4);
    ticks(POR - 1);
    expectOut(1'b0, 2'b00, "R5 delay restarted, one tick short");
    ticks(1);
    expectOut(1'b1, 2'b00, "R4 enable after full delay");

    // R3 / R10: short undervoltage excursion
    aboveUv = 1'b0;
    cycles(3);
    ticks(FLT - 1);
    expectOut(1'b1, 2'b00, "R3 R10 excursion one tick short");
    aboveUv = 1'b1;
    cycles(3);
    aboveUv = 1'b0;
    cycles(3);
    ticks(FLT - 1);
    expectOut(1'b1, 2'b00, "R3 filter restarted on new excursion");
    ticks(1);
    expectOut(1'b0, 2'b01, "R2 qualified undervoltage fault");

    // R7: unfiltered restore
    aboveUv = 1'b1;
    cycles(SYN);
    expectOut(1'b0, 2'b01, "R7 before latency elapses");
    cycles(1);
    expectOut(1'b1, 2'b00, "R7 restored without delay");

    // R8: overvoltage path
    aboveOv = 1'b1;
    cycles(3);
    ticks(FLT - 1);
    expectOut(1'b1, 2'b00, "R8 overvoltage one tick short");
    ticks(1);
    expectOut(1'b0, 2'b10, "R8 R9 qualified overvoltage fault");
    aboveOv = 1'b0;
    cycles(3);
    expectOut(1'b1, 2'b00, "R7 restored after overvoltage");
    aboveOv = 1'b1;
    cycles(10);
    expectOut(1'b1, 2'b00, "R2 no ticks, no drop");
    aboveOv = 1'b0;
    cycles(3);

    // R6: lockout
    supplyOk = 1'b0;
    cycles(1);
    expectOut(1'b0, 2'b00, "R6 lockout drops enable");
    ticks(POR + 2);
    expectOut(1'b0, 2'b00, "R6 held off during lockout");
    supplyOk = 1'b1;
    cycles(2);
    ticks(POR - 1);
    expectOut(1'b0, 2'b00, "R6 new delay after lockout");
    ticks(1);
    expectOut(1'b1, 2'b00, "R4 enable after lockout delay");

    // R9: undervoltage has priority
    aboveUv = 1'b0;
    aboveOv = 1'b1;
    cycles(3);
    ticks(FLT);
    expectOut(1'b0, 2'b01, "R9 undervoltage priority");

    finished = 1'b1;
    summary();
  end

endmodule